// File: doc/BRIEF.md
# MDIO Management Master

This block is the serial master of a two-wire PHY management bus. It generates the management clock and drives or releases the data line. It also runs complete register reads and writes for a host that presents one request at a time. A request chooses read or write, chooses the short (Clause 22) or extended (Clause 45) frame family, and carries a 5-bit PHY address, a 21-bit address field and 16 bits of write data. The host waits on `busy_o`. It then gets a one-cycle `done_o` pulse, and after a read it takes the result on `rdata_o`.

For an extended access the block first sends an address frame and then a second frame that reads or writes. Both frames carry the same device field. On every read the block checks the single turnaround sample returned by the PHY. A PHY that does not answer produces a run of flush clocks and a result of all ones instead of data. The clock timing comes from two cycle-count parameters: `HALF_CYC` sets each low phase and each high phase of driven bits, and `RD_HIGH_CYC` sets the longer high phase of bits the PHY drives.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 bit times in which the data line is driven to 1.
- R2: A short-format frame sends start bits 0 then 1 after the preamble, then opcode 1,0 for a read or 0,1 for a write. Its register field is `req_addr_i[4:0]`.
- R3: An extended request sends two frames. Both use start bits 0,0. The first frame has opcode 0,0 and carries `req_addr_i[15:0]` as its data. The second has opcode 1,1 for a read or 0,1 for a write. Both frames carry `req_addr_i[20:16]` as the device field.
- R4: After the opcode come the 5 PHY address bits and then the 5-bit register or device field, both MSB first.
- R5: In write and address frames the master drives turnaround 1,0, then 16 data bits MSB first, then releases the line for one further bit time. A frame of this kind is 65 bit times long.
- R6: In a read frame the line is released after the register field and one turnaround bit is sampled. If that sample is 0, 16 data bits are captured MSB first into `rdata_o`, followed by one trailing bit time. The frame is 64 bit times long.
- R7: If the read turnaround sample is 1, the master clocks 32 more released bit times, so the frame is 79 bit times long, and `rdata_o` becomes 0xFFFF.
- R8: MDC is low for `HALF_CYC` cycles in every bit. It is high for `HALF_CYC` cycles in driven bits and for `RD_HIGH_CYC` cycles in released bits. Driven data changes only on the cycle in which MDC falls. Input data is sampled on the clock edge at which MDC falls.
- R9: `mdio_oe_o` is 1 exactly during driven bit times and 0 whenever the block is idle.
- R10: `busy_o` rises in the cycle after a request is accepted and stays high until `done_o` pulses for one cycle. Requests made while busy are ignored. `rdata_o` is unchanged by writes.
- R11: After reset, MDC, `mdio_oe_o`, `busy_o` and `done_o` are 0 and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when not busy |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_c45_i | input | 1 | 1 = extended two-frame access |
| req_phy_i | input | 5 | PHY address |
| req_addr_i | input | 21 | [20:16] device, [15:0] extended address, [4:0] short register |
| req_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The hardest cases to reach are the released bit times: the turnaround sample, the 16 captured bits and the 32-cycle flush. They need a device that answers in step with the block's own clock. The bench therefore models a responder that follows MDC falling edges. It counts bit times from the start of each request and places a 0 turnaround and the data word at the right positions, or leaves the line high to act as an absent device. The sweep crosses read and write, both frame families and responder present or absent over several address and data patterns. One run also fires competing requests in the middle of a transaction.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W   = 5;
  localparam int REG_W   = 5;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = REG_W + DATA_W;
  localparam int PRE_LEN = 32;
  localparam int HDR_LEN = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int FRAME_W = HDR_LEN + 2 + DATA_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DRIVE, ST_TA, ST_RX, ST_TAIL
  } mdio_st_e;

  function automatic logic [1:0] op_code(logic c45, logic wr);
    return wr ? 2'b01 : (c45 ? 2'b11 : 2'b10);
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(
      logic c45, logic [1:0] op, logic [PHY_W-1:0] phy,
      logic [REG_W-1:0] rf, logic [DATA_W-1:0] d);
    return {{PRE_LEN{1'b1}}, 1'b0, ~c45, op, phy, rf, 2'b10, d};
  endfunction
endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer #(
  parameter int HALF_CYC    = 63,
  parameter int RD_HIGH_CYC = 88
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic long_i,
  output logic mdc_o,
  output logic bit_end_o
);
  localparam int MAX_CYC = (HALF_CYC > RD_HIGH_CYC) ? HALF_CYC : RD_HIGH_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             hi_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             wrap;

  assign lim  = (hi_q && long_i) ? CNT_W'(RD_HIGH_CYC - 1) : CNT_W'(HALF_CYC - 1);
  assign wrap = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!run_i) begin
      hi_q  <= 1'b0;
      cnt_q <= '0;
    end else if (wrap) begin
      hi_q  <= ~hi_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o     = hi_q;
  assign bit_end_o = run_i & hi_q & wrap;
endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb_o = sr_q[W-1];
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  input  logic         fill_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (fill_i)  q_o <= '1;
    else if (shift_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYC    = 63,
  parameter int RD_HIGH_CYC = 88
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_c45_i,
  input  logic [PHY_W-1:0]  req_phy_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int LEFT_W = $clog2(FRAME_W);
  localparam logic [LEFT_W-1:0] LEFT_WR = LEFT_W'(FRAME_W - 1);
  localparam logic [LEFT_W-1:0] LEFT_RD = LEFT_W'(HDR_LEN - 1);
  localparam logic [LEFT_W-1:0] LEFT_FL = LEFT_W'(PRE_LEN - 1);
  localparam logic [LEFT_W-1:0] LEFT_RX = LEFT_W'(DATA_W - 1);

  mdio_st_e          st_q;
  logic [LEFT_W-1:0] left_q;
  logic              addr_ph_q, wr_q, done_q;
  logic [PHY_W-1:0]  phy_q;
  logic [REG_W-1:0]  dev_q;
  logic [DATA_W-1:0] wdata_q;

  logic               run, long_bit, bit_end, last;
  logic               tx_load, tx_msb;
  logic [FRAME_W-1:0] tx_data, main_in, addr_in, main_q;
  logic [REG_W-1:0]   rf_in;

  assign run      = (st_q != ST_IDLE);
  assign long_bit = (st_q == ST_TA) || (st_q == ST_RX) || (st_q == ST_TAIL);
  assign last     = (left_q == '0);
  assign rf_in    = req_c45_i ? req_addr_i[ADDR_W-1:DATA_W] : req_addr_i[REG_W-1:0];

  assign main_in = build_frame(req_c45_i, op_code(req_c45_i, req_write_i),
                               req_phy_i, rf_in, req_wdata_i);
  assign addr_in = build_frame(1'b1, 2'b00, req_phy_i,
                               req_addr_i[ADDR_W-1:DATA_W], req_addr_i[DATA_W-1:0]);
  assign main_q  = build_frame(1'b1, op_code(1'b1, wr_q), phy_q, dev_q, wdata_q);

  always_comb begin
    tx_load = 1'b0;
    tx_data = main_in;
    if (st_q == ST_IDLE && req_valid_i) begin
      tx_load = 1'b1;
      tx_data = req_c45_i ? addr_in : main_in;
    end else if (st_q == ST_TAIL && bit_end && last && addr_ph_q) begin
      tx_load = 1'b1;
      tx_data = main_q;
    end
  end

  mdio_bit_timer #(.HALF_CYC(HALF_CYC), .RD_HIGH_CYC(RD_HIGH_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .long_i(long_bit),
    .mdc_o(mdc_o), .bit_end_o(bit_end)
  );

  mdio_tx_shift #(.W(FRAME_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tx_load), .data_i(tx_data),
    .shift_i(st_q == ST_DRIVE && bit_end), .msb_o(tx_msb)
  );

  mdio_rx_shift #(.W(DATA_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .shift_i(st_q == ST_RX && bit_end), .bit_i(mdio_i),
    .fill_i(st_q == ST_TA && bit_end && mdio_i), .q_o(rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      left_q    <= '0;
      addr_ph_q <= 1'b0;
      wr_q      <= 1'b0;
      phy_q     <= '0;
      dev_q     <= '0;
      wdata_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          st_q      <= ST_DRIVE;
          addr_ph_q <= req_c45_i;
          wr_q      <= req_write_i;
          phy_q     <= req_phy_i;
          dev_q     <= req_addr_i[ADDR_W-1:DATA_W];
          wdata_q   <= req_wdata_i;
          left_q    <= (req_c45_i || req_write_i) ? LEFT_WR : LEFT_RD;
        end
        ST_DRIVE: if (bit_end) begin
          if (!last) left_q <= left_q - 1'b1;
          else if (!addr_ph_q && !wr_q) st_q <= ST_TA;
          else begin
            st_q   <= ST_TAIL;
            left_q <= '0;
          end
        end
        ST_TA: if (bit_end) begin
          if (mdio_i) begin
            st_q   <= ST_TAIL;
            left_q <= LEFT_FL;
          end else begin
            st_q   <= ST_RX;
            left_q <= LEFT_RX;
          end
        end
        ST_RX: if (bit_end) begin
          if (last) st_q <= ST_TAIL;
          else      left_q <= left_q - 1'b1;
        end
        ST_TAIL: if (bit_end) begin
          if (!last) left_q <= left_q - 1'b1;
          else if (addr_ph_q) begin
            addr_ph_q <= 1'b0;
            st_q      <= ST_DRIVE;
            left_q    <= wr_q ? LEFT_WR : LEFT_RD;
          end else begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mdio_oe_o = (st_q == ST_DRIVE);
  assign mdio_o    = mdio_oe_o & tx_msb;
  assign busy_o    = run;
  assign done_o    = done_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic busy_o,
  input logic done_o,
  input logic mdc_o,
  input logic mdio_o,
  input logic mdio_oe_o
);
  // R9
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdio_oe_o);

  // R8
  idle_mdc_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdc_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o) && !busy_o);

  // R10
  start_by_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_valid_i));

  // R8
  data_hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o) && mdio_oe_o) |-> $stable(mdio_o));

  // R9
  oe_switch_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(mdio_oe_o) && $past(busy_o) && busy_o) |-> $fell(mdc_o));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .busy_o(busy_o),
  .done_o(done_o), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int HALF = 2;
  localparam int RDH  = 3;
  localparam int MAXB = 256;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_c45 = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, mdc, mdio_d, mdio_oe;
  logic [15:0] rdata;
  logic        mdio_in = 1'b1;

  mdio_master #(.HALF_CYC(HALF), .RD_HIGH_CYC(RDH)) u_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_c45_i(req_c45), .req_phy_i(req_phy), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdio_d), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // responder state
  bit        t_read, t_resp;
  int        t_base;
  bit [15:0] t_data;

  function automatic bit resp_bit(int g);
    int rel = g - t_base;
    if (!t_read || !t_resp) return 1'b1;
    if (rel == 46) return 1'b0;
    if (rel >= 47 && rel <= 62) return t_data[62 - rel];
    return 1'b1;
  endfunction

  // monitor
  bit prev_mdc = 1'b0;
  int run_len = 0, rise_n = 0, fall_n = 0;
  bit rec_d [MAXB];
  bit rec_oe[MAXB];
  int hi_len[MAXB];
  int lo_len[MAXB];

  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin
      if (rise_n < MAXB) begin
        rec_d[rise_n]  = mdio_d;
        rec_oe[rise_n] = mdio_oe;
        lo_len[rise_n] = run_len;
      end
      rise_n++;
      run_len = 1;
    end else if (!mdc && prev_mdc) begin
      if (fall_n < MAXB) hi_len[fall_n] = run_len;
      fall_n++;
      run_len = 1;
      mdio_in = resp_bit(fall_n);
    end else begin
      run_len++;
    end
    prev_mdc = mdc;
  end

  // expected stream
  bit exp_d [MAXB];
  bit exp_oe[MAXB];
  bit exp_lg[MAXB];
  int exp_tg[MAXB];
  int exp_n;

  task automatic push(bit d, bit oe, bit lg, int tg);
    exp_d[exp_n] = d; exp_oe[exp_n] = oe; exp_lg[exp_n] = lg; exp_tg[exp_n] = tg;
    exp_n++;
  endtask

  task automatic push_frame(bit c45, bit [1:0] op, bit [4:0] phy, bit [4:0] rf,
                            bit [15:0] d, bit rd, bit resp);
    int st = c45 ? 3 : 2;
    for (int i = 0; i < 32; i++) push(1'b1, 1'b1, 1'b0, 1);
    push(1'b0, 1'b1, 1'b0, st);
    push(!c45, 1'b1, 1'b0, st);
    push(op[1], 1'b1, 1'b0, st);
    push(op[0], 1'b1, 1'b0, st);
    for (int i = 4; i >= 0; i--) push(phy[i], 1'b1, 1'b0, 4);
    for (int i = 4; i >= 0; i--) push(rf[i], 1'b1, 1'b0, 4);
    if (!rd) begin
      push(1'b1, 1'b1, 1'b0, 5);
      push(1'b0, 1'b1, 1'b0, 5);
      for (int i = 15; i >= 0; i--) push(d[i], 1'b1, 1'b0, 5);
      push(1'b0, 1'b0, 1'b1, 5);
    end else begin
      for (int i = 0; i < (resp ? 18 : 33); i++) push(1'b0, 1'b0, 1'b1, resp ? 6 : 7);
    end
  endtask

  function automatic string tname(int t);
    case (t)
      1: return "R1 preamble";
      2: return "R2 short start/opcode";
      3: return "R3 extended start/opcode";
      4: return "R4 phy/register fields";
      5: return "R5 turnaround/write data";
      6: return "R6 answered read";
      default: return "R7 unanswered read";
    endcase
  endfunction

  bit [15:0] last_rd = 16'h0000;

  task automatic run_txn(bit w, bit c45, bit [4:0] phy, bit [20:0] addr,
                         bit [15:0] wd, bit resp, bit inject);
    int bad_tg[8];
    bit use_tg[8];
    int bad_oe = 0, bad_len = 0, guard = 0;
    bit got = 1'b0;
    bit [4:0] rf = c45 ? addr[20:16] : addr[4:0];
    t_read = !w; t_resp = resp; t_data = wd ^ 16'h5A3C; t_base = c45 ? 65 : 0;
    exp_n = 0;
    if (c45) push_frame(1'b1, 2'b00, phy, addr[20:16], addr[15:0], 1'b0, 1'b0);
    push_frame(c45, w ? 2'b01 : (c45 ? 2'b11 : 2'b10), phy, rf, wd, !w, resp);
    @(negedge clk);
    rise_n = 0; fall_n = 0; run_len = 0; mdio_in = 1'b1;
    req_valid = 1'b1; req_write = w; req_c45 = c45;
    req_phy = phy; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
    if (inject) begin
      repeat (40) @(negedge clk);
      req_valid = 1'b1; req_write = !w; req_c45 = !c45;
      req_phy = ~phy; req_addr = ~addr; req_wdata = ~wd;
      repeat (12) @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R10 busy during ignored request", int'(busy), 1);
    end
    while (!got && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (done) got = 1'b1;
    end
    chk(got, "R10 done pulse seen", int'(got), 1);
    @(negedge clk);
    chk(!done && !busy, "R10 done single cycle, idle", int'({done, busy}), 0);
    for (int t = 0; t < 8; t++) begin bad_tg[t] = 0; use_tg[t] = 1'b0; end
    for (int i = 0; i < exp_n && i < MAXB; i++) begin
      if (rec_oe[i] != exp_oe[i]) bad_oe++;
      if (exp_oe[i]) begin
        use_tg[exp_tg[i]] = 1'b1;
        if (rec_d[i] != exp_d[i]) bad_tg[exp_tg[i]]++;
      end
      if (hi_len[i] != (exp_lg[i] ? RDH : HALF)) bad_len++;
      if (i > 0 && lo_len[i] != HALF) bad_len++;
    end
    for (int t = 1; t < 8; t++)
      if (use_tg[t]) chk(bad_tg[t] == 0, tname(t), bad_tg[t], 0);
    chk(bad_oe == 0, "R9 output enable per bit", bad_oe, 0);
    chk(bad_len == 0, "R8 phase lengths", bad_len, 0);
    chk(rise_n == exp_n,
        w ? "R5 bit count" : (resp ? "R6 bit count" : "R7 bit count"), rise_n, exp_n);
    if (w) chk(rdata == last_rd, "R10 rdata unchanged by write", rdata, last_rd);
    else if (resp) begin
      chk(rdata == t_data, "R6 read data", rdata, t_data);
      last_rd = t_data;
    end else begin
      chk(rdata == 16'hFFFF, "R7 all-ones result", rdata, 16'hFFFF);
      last_rd = 16'hFFFF;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog expired: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(!mdc && !mdio_oe && !busy && !done, "R11 reset outputs",
        int'({mdc, mdio_oe, busy, done}), 0);
    chk(rdata == 16'h0, "R11 reset rdata", rdata, 0);
    for (int k = 0; k < 6; k++)
      for (int w = 0; w < 2; w++)
        for (int c = 0; c < 2; c++)
          for (int r = 0; r < 2; r++)
            run_txn(w[0], c[0], 5'((k * 7 + 3 + r) & 31),
                    21'((k * 21'h0B5A7 + c * 21'h13579) ^ (21'h1F << (k * 3))),
                    16'(k * 16'h9E37 + w * 16'h1111 + 16'h8001), r[0], k == 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule